// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries from a page table held in memory: first a directory entry, then a table entry. A requester hands over one address at a time through a valid/ready handshake. The walker then issues word reads on a separate memory request channel and takes each returned word from a response channel. It presents the result, either a physical address or a fault naming the level where the walk stopped, and holds it until the requester acknowledges it.

A control word and a root input are sampled when a request is accepted. If the enable bit of the control word is clear, the walker does no memory reads. It returns the virtual address unchanged on the next cycle. Pages are 4 KiB. The virtual address splits into a 10-bit directory index in bits 31:22, a 10-bit table index in bits 21:12 and a 12-bit byte offset in bits 11:0. Entries are 4-byte words, and bit 0 of each entry is its present flag.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: When a request is accepted with bit 31 of `ctrl_i` at 0, the response appears on the next cycle. It has `rsp_paddr_o` equal to the virtual address and `rsp_fault_o` at 0, and no memory read is issued.
- R3: With bit 31 of `ctrl_i` at 1, the first memory read goes to address {root[31:12], vaddr[31:22], 2'b00}. The low 12 bits of the root are ignored.
- R4: The second read is issued only after the directory word has returned. It goes to address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R5: When both entries have bit 0 at 1, the response has `rsp_fault_o` at 0 and `rsp_paddr_o` equal to {table_entry[31:12], vaddr[11:0]}.
- R6: A directory entry with bit 0 at 0 ends the walk at once. The response has `rsp_fault_o` at 1 and `rsp_level_o` at 0, and no table read is issued.
- R7: A table entry with bit 0 at 0 gives a response with `rsp_fault_o` at 1 and `rsp_level_o` at 1.
- R8: A memory read request stays valid with an unchanged address until `mem_req_ready_i` is seen.
- R9: The response stays valid with unchanged paddr, fault and level until `rsp_ack_i`. The cycle after the acknowledge, the walker is idle with `req_ready_o` at 1. `req_ready_o` is 1 only when no walk is in flight and no response is pending.
- R10: `mem_rsp_valid_i` has no effect unless the walker is waiting for a read it has issued. A stray response while a read request is still stalled changes neither the result nor the walk.
- R11: The enable bit and the root are used as sampled at request acceptance. Changes to them during a walk do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word; bit 31 enables translation |
| root_i | input | 32 | Physical base of the page directory (bits 31:12 used) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| rsp_valid_o | output | 1 | Result valid, held until acknowledged |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Walk hit an entry whose present bit is clear |
| rsp_level_o | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_ack_i | input | 1 | Requester acknowledges the result |
| mem_req_valid_o | output | 1 | Memory word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry word |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |

## Verification
Two events can meet in one cycle. The first case is a held response being acknowledged while the next request is already valid. The bench raises the new request during the hold and keeps it raised through the acknowledge. It then judges cycle by cycle that `req_ready_o` stays low until the walker is back in idle and that the request is taken only on the cycle after. The second case is a memory response that arrives while the matching read request is still stalled. The bench injects a stray present-looking word during each stalled request cycle and requires the final address to match the model built from the real table contents.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WALK_IDLE,
    WALK_DIR_REQ,
    WALK_DIR_WAIT,
    WALK_TBL_REQ,
    WALK_TBL_WAIT,
    WALK_DONE
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_level_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  ptw_pkg::walk_level_e level_i,
  input  logic [ADDR_W-1:0]    root_i,
  input  logic [ADDR_W-1:0]    dir_entry_i,
  input  logic [ADDR_W-1:0]    vaddr_i,
  output logic [ADDR_W-1:0]    addr_o
);
  import ptw_pkg::*;

  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int PAD_W   = OFF_W - IDX_W;
  localparam int DIR_LSB = ADDR_W - IDX_W;
  localparam int TBL_LSB = OFF_W;

  logic [FRAME_W-1:0] base;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    if (level_i == LVL_TBL) begin
      base = dir_entry_i[ADDR_W-1:OFF_W];
      idx  = vaddr_i[TBL_LSB +: IDX_W];
    end else begin
      base = root_i[ADDR_W-1:OFF_W];
      idx  = vaddr_i[DIR_LSB +: IDX_W];
    end
    addr_o = {base, idx, {PAD_W{1'b0}}};
  end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int PRESENT_BIT = 0
) (
  input  logic [ADDR_W-1:0] entry_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic              present_o,
  output logic [ADDR_W-1:0] paddr_o
);
  assign present_o = entry_i[PRESENT_BIT];
  assign paddr_o   = {entry_i[ADDR_W-1:OFF_W], vaddr_i[OFF_W-1:0]};
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm #(
  parameter int ADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    vaddr_i,
  input  logic [ADDR_W-1:0]    root_i,
  input  logic                 paging_en_i,
  output logic                 req_ready_o,
  input  logic                 mem_req_ready_i,
  output logic                 mem_req_valid_o,
  input  logic                 mem_rsp_valid_i,
  input  logic [ADDR_W-1:0]    mem_rsp_data_i,
  input  logic                 present_i,
  input  logic [ADDR_W-1:0]    leaf_paddr_i,
  output ptw_pkg::walk_level_e walk_lvl_o,
  output logic [ADDR_W-1:0]    vaddr_q_o,
  output logic [ADDR_W-1:0]    root_q_o,
  output logic [ADDR_W-1:0]    dir_q_o,
  input  logic                 rsp_ack_i,
  output logic                 rsp_valid_o,
  output logic [ADDR_W-1:0]    rsp_paddr_o,
  output logic                 rsp_fault_o,
  output logic                 rsp_level_o
);
  import ptw_pkg::*;

  walk_state_e       state_q;
  walk_level_e       level_q;
  logic [ADDR_W-1:0] vaddr_q, root_q, dir_q, paddr_q;
  logic              fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      level_q <= LVL_DIR;
      vaddr_q <= '0;
      root_q  <= '0;
      dir_q   <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        WALK_IDLE: if (req_valid_i) begin
          vaddr_q <= vaddr_i;
          root_q  <= root_i;
          fault_q <= 1'b0;
          level_q <= LVL_DIR;
          if (paging_en_i) begin
            state_q <= WALK_DIR_REQ;
          end else begin
            paddr_q <= vaddr_i;
            state_q <= WALK_DONE;
          end
        end
        WALK_DIR_REQ: if (mem_req_ready_i) state_q <= WALK_DIR_WAIT;
        WALK_DIR_WAIT: if (mem_rsp_valid_i) begin
          if (present_i) begin
            dir_q   <= mem_rsp_data_i;
            state_q <= WALK_TBL_REQ;
          end else begin
            fault_q <= 1'b1;
            level_q <= LVL_DIR;
            paddr_q <= '0;
            state_q <= WALK_DONE;
          end
        end
        WALK_TBL_REQ: if (mem_req_ready_i) state_q <= WALK_TBL_WAIT;
        WALK_TBL_WAIT: if (mem_rsp_valid_i) begin
          if (present_i) begin
            paddr_q <= leaf_paddr_i;
          end else begin
            fault_q <= 1'b1;
            level_q <= LVL_TBL;
            paddr_q <= '0;
          end
          state_q <= WALK_DONE;
        end
        WALK_DONE: if (rsp_ack_i) state_q <= WALK_IDLE;
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == WALK_IDLE);
  assign mem_req_valid_o = (state_q == WALK_DIR_REQ) || (state_q == WALK_TBL_REQ);
  assign walk_lvl_o      = (state_q == WALK_TBL_REQ) ? LVL_TBL : LVL_DIR;
  assign vaddr_q_o       = vaddr_q;
  assign root_q_o        = root_q;
  assign dir_q_o         = dir_q;
  assign rsp_valid_o     = (state_q == WALK_DONE);
  assign rsp_paddr_o     = paddr_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = level_q;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int CTRL_W      = 32,
  parameter int EN_BIT      = 31,
  parameter int PRESENT_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] root_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic              rsp_level_o,
  input  logic              rsp_ack_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i
);
  import ptw_pkg::*;

  walk_level_e       walk_lvl;
  logic [ADDR_W-1:0] vaddr_q, root_q, dir_q, leaf_paddr;
  logic              present;

  ptw_walk_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .vaddr_i         (req_vaddr_i),
    .root_i          (root_i),
    .paging_en_i     (ctrl_i[EN_BIT]),
    .req_ready_o     (req_ready_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .present_i       (present),
    .leaf_paddr_i    (leaf_paddr),
    .walk_lvl_o      (walk_lvl),
    .vaddr_q_o       (vaddr_q),
    .root_q_o        (root_q),
    .dir_q_o         (dir_q),
    .rsp_ack_i       (rsp_ack_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_level_o     (rsp_level_o)
  );

  ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .level_i     (walk_lvl),
    .root_i      (root_q),
    .dir_entry_i (dir_q),
    .vaddr_i     (vaddr_q),
    .addr_o      (mem_req_addr_o)
  );

  ptw_entry_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PRESENT_BIT(PRESENT_BIT)) u_dec (
    .entry_i   (mem_rsp_data_i),
    .vaddr_i   (vaddr_q),
    .present_o (present),
    .paddr_o   (leaf_paddr)
  );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int CTRL_W = 32,
  parameter int EN_BIT = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [ADDR_W-1:0] root_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic              rsp_fault_o,
  input logic              rsp_level_o,
  input logic              rsp_ack_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o
);
  localparam int PAD_W   = OFF_W - IDX_W;
  localparam int DIR_LSB = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] va_seen, root_seen;
  logic              first_read;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_seen    <= '0;
      root_seen  <= '0;
      first_read <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      va_seen    <= req_vaddr_i;
      root_seen  <= root_i;
      first_read <= 1'b1;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      first_read <= 1'b0;
    end
  end

  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !ctrl_i[EN_BIT]) |=>
      (rsp_valid_o && !rsp_fault_o && rsp_paddr_o == $past(req_vaddr_i)));

  a_r3_dir_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && first_read) |->
      (mem_req_addr_o == {root_seen[ADDR_W-1:OFF_W], va_seen[DIR_LSB +: IDX_W], {PAD_W{1'b0}}}));

  a_r4_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[PAD_W-1:0] == '0));

  a_r5_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFF_W-1:0] == va_seen[OFF_W-1:0]));

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r9_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ack_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_level_o)));

  a_r9_back_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ack_i) |=> (req_ready_o && !rsp_valid_o));

  a_r9_single_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !mem_req_valid_o));

endmodule

bind ptw_walker ptw_walker_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W), .EN_BIT(EN_BIT)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ctrl_i          (ctrl_i),
  .root_i          (root_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_vaddr_i     (req_vaddr_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_level_o     (rsp_level_o),
  .rsp_ack_i       (rsp_ack_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0, root = '0, req_vaddr = '0;
  logic        req_valid = 1'b0, rsp_ack = 1'b0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_level, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;

  always #5 clk = ~clk;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .root_i(root),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .rsp_level_o(rsp_level), .rsp_ack_i(rsp_ack),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit busy_ref = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr[$];
  string       exp_tag[$];

  int          stall_cfg = 0, lat_cfg = 0;
  bit          stray_cfg = 0;
  int          stall_cnt = -1, lat_cnt = -1;
  logic [31:0] rsp_word, held_addr, head_addr;
  string       head_tag;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // behavioural reference: queues the reads and returns the result
  task automatic ref_walk(input logic [31:0] va, input bit en, input logic [31:0] rt,
                          output logic [31:0] pa, output bit flt, output bit lvl);
    logic [31:0] da, ta, d, t;
    pa = 32'h0; flt = 0; lvl = 0;
    if (!en) begin
      pa = va;
      return;
    end
    da = (rt & 32'hFFFF_F000) + (va >> 22) * 4;
    exp_addr.push_back(da); exp_tag.push_back("R3");
    d = rd(da);
    if (d[0] == 1'b0) begin
      flt = 1; lvl = 0;
      return;
    end
    ta = (d & 32'hFFFF_F000) + ((va >> 12) & 32'h3FF) * 4;
    exp_addr.push_back(ta); exp_tag.push_back("R4");
    t = rd(ta);
    if (t[0] == 1'b0) begin
      flt = 1; lvl = 1;
      return;
    end
    pa = (t & 32'hFFFF_F000) | (va & 32'hFFF);
  endtask

  // memory responder
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hA5A5_A5A4;
      if (lat_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_word;
        lat_cnt = -1;
      end else if (lat_cnt > 0) begin
        lat_cnt--;
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
      end else if (mem_req_valid && lat_cnt < 0 && !mem_rsp_valid) begin
        if (stall_cnt < 0) begin
          stall_cnt = stall_cfg;
          held_addr = mem_req_addr;
        end
        chk(mem_req_addr == held_addr, "R8", "stalled request address", mem_req_addr, held_addr);
        if (stall_cnt == 0) begin
          mem_req_ready = 1'b1;
          stall_cnt = -1;
          if (exp_addr.size() == 0) begin
            chk(1'b0, "R2 R6", "unexpected memory read", mem_req_addr, 32'h0);
          end else begin
            head_addr = exp_addr.pop_front();
            head_tag  = exp_tag.pop_front();
            chk(mem_req_addr == head_addr, head_tag, "entry read address", mem_req_addr, head_addr);
          end
          rsp_word = rd(mem_req_addr);
          lat_cnt  = lat_cfg;
        end else begin
          stall_cnt--;
          if (stray_cfg) begin
            mem_rsp_valid = 1'b1;  // stray word while request stalled (R10)
            mem_rsp_data  = 32'h7777_7001;
          end
        end
      end
    end
  end

  // one cycle, with per-cycle comparison of the handshake state
  task automatic tick();
    @(negedge clk);
    chk(req_ready == !busy_ref, "R9", "ready only when idle", {31'b0, req_ready}, {31'b0, !busy_ref});
    if (rsp_valid) chk(busy_ref, "R9", "response only while busy", {31'b0, busy_ref}, 32'h1);
  endtask

  task automatic do_walk(input logic [31:0] va, input bit en, input logic [31:0] rt,
                         input int stall, input int lat, input bit stray, input int hold,
                         input bit chg_mid, input bit pend, input logic [31:0] next_va,
                         input string tag);
    logic [31:0] e_pa, s_pa;
    bit e_flt, e_lvl, s_flt, s_lvl;
    int cyc;
    stall_cfg = stall; lat_cfg = lat; stray_cfg = stray;
    ref_walk(va, en, rt, e_pa, e_flt, e_lvl);
    ctrl = en ? 32'h8000_0001 : 32'h7FFF_FFFF;
    root = rt;
    req_vaddr = va;
    chk(req_ready, "R9", "idle before request", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1;
    busy_ref = 1;
    tick();
    req_valid = 1'b0;
    req_vaddr = 32'hDEAD_0000;
    if (chg_mid) begin  // R11: inputs move after acceptance
      ctrl = ~ctrl;
      root = root ^ 32'hFFFF_F000;
    end
    cyc = 1;
    while (!rsp_valid && cyc < 60) begin
      tick();
      cyc++;
    end
    chk(rsp_valid, tag, "response arrived", {31'b0, rsp_valid}, 32'h1);
    if (!en) chk(cyc == 1, "R2", "bypass latency", cyc, 1);
    chk(rsp_fault == e_flt, tag, "fault flag", {31'b0, rsp_fault}, {31'b0, e_flt});
    if (e_flt) chk(rsp_level == e_lvl, tag, "fault level", {31'b0, rsp_level}, {31'b0, e_lvl});
    else       chk(rsp_paddr == e_pa, tag, "physical address", rsp_paddr, e_pa);
    chk(exp_addr.size() == 0, tag, "all expected reads issued", exp_addr.size(), 0);
    exp_addr.delete(); exp_tag.delete();
    s_pa = rsp_paddr; s_flt = rsp_fault; s_lvl = rsp_level;
    for (int i = 0; i < hold; i++) begin
      if (pend) begin
        req_valid = 1'b1;
        req_vaddr = next_va;
      end
      tick();
      chk(rsp_valid && rsp_paddr == s_pa && rsp_fault == s_flt && rsp_level == s_lvl,
          "R9", "response held", rsp_paddr, s_pa);
    end
    rsp_ack = 1'b1;
    busy_ref = 0;
    tick();
    rsp_ack = 1'b0;
    chk(!rsp_valid && req_ready, "R9", "idle after ack", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    mem[32'h0010_0004] = 32'h0020_0003;
    mem[32'h0020_000C] = 32'h0055_5F01;
    mem[32'h0010_0FFC] = 32'h0030_0001;
    mem[32'h0030_0FFC] = 32'hABCD_E001;
    mem[32'h0010_0008] = 32'h0040_0FFE;
    mem[32'h0020_0010] = 32'h0066_6000;
    mem[32'h0070_0000] = 32'h0080_0001;
    mem[32'h0080_0004] = 32'h0123_4001;
    mem[32'h0020_0000] = 32'h0099_9001;

    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "state in reset",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    tick();
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "state after reset",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    do_walk(32'h1234_5678, 0, 32'h0010_0000, 0, 0, 0, 0, 0, 0, 0, "R2");
    do_walk(32'h0040_3ABC, 1, 32'h0010_0ABC, 0, 0, 0, 1, 0, 0, 0, "R5");
    do_walk(32'hFFFF_FFFF, 1, 32'h0010_0000, 3, 2, 1, 2, 0, 0, 0, "R10");
    do_walk(32'h0080_0123, 1, 32'h0010_0000, 1, 1, 0, 0, 0, 0, 0, "R6");
    do_walk(32'h0040_4FFF, 1, 32'h0010_0000, 0, 3, 1, 1, 0, 0, 0, "R7");
    do_walk(32'h0000_1234, 1, 32'h0070_0123, 2, 0, 0, 0, 1, 0, 0, "R11");
    do_walk(32'h0040_3000, 1, 32'h0010_0000, 0, 0, 0, 3, 0, 1, 32'h0040_0001, "R5");
    do_walk(32'h0040_0001, 1, 32'h0010_0000, 0, 0, 0, 0, 0, 0, 0, "R4");
    do_walk(32'h0040_3ABC, 0, 32'h0010_0000, 0, 0, 0, 1, 1, 0, 0, "R11");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule